// File: doc/BRIEF.md
# Fixed-Frequency Winding Current Chopper

This block regulates the current in one winding of a bipolar motor by chopping at a fixed rate. A free-running period counter restarts the chopping cycle every `PERIOD` clocks. At each restart the full bridge is switched into conduction with the polarity that the winding sign asks for. An external current comparator reports when the winding current reaches its setpoint. Once a short blanking interval after the period start has passed, the first accepted comparator trip moves the bridge into a decay pattern, and that pattern holds until the period ends.

Three decay behaviours can be selected. Slow decay recirculates the current through both low-side switches. Fast decay drives the bridge in reverse. Mixed decay runs fast decay for the first quarter of the time left in the period and then changes to slow decay. When the setpoint is zero, the bridge stays in slow decay. The four gate commands pass through a dead-time stage that never lets one conducting pattern hand over directly to another. When the enable is low, all gates are off and the period counter is held at zero.

The period and the blanking length are derived from the clock frequency, the chopping frequency and the blanking time. With a 50 MHz clock, a 30 kHz chopping rate and a 4 µs blanking time, the period is 1667 cycles and the blanking window is 200 cycles.

Top module: `chop_ctrl`

## Requirements
- R1: In reset, and in every cycle that follows a cycle in which `en` was sampled low, `gate` is 4'b0000. While `en` is low the period count is held at 0, so the first enabled cycle starts a new period.
- R2: With `sign_pos` = 1 and no decay active, the drive pattern is high side of output 1 plus low side of output 2. With the bit order {hs_out1, ls_out1, hs_out2, ls_out2}, this is `gate` = 4'b1001.
- R3: A `trip` sampled while the period count is below `BLANK` has no effect, and the bridge stays in drive.
- R4: `decay_sel` = 2'b00 (slow): after an accepted trip the bridge shows 4'b0101 (both low sides) until the period ends.
- R5: `decay_sel` = 2'b10 or 2'b11 (fast): after an accepted trip the bridge shows the reverse of the drive diagonal until the period ends. This is 4'b0110 for a positive sign.
- R6: `decay_sel` = 2'b01 (mixed): for a trip accepted at count t, fast decay holds for floor((PERIOD-1-t)/4) cycles and is followed by slow decay for the rest of the period.
- R7: While `zero_set` = 1, the drive phase shows the slow pattern 4'b0101 and trips are not accepted.
- R8: Any change from one non-zero gate pattern to a different one passes through at least `DEAD_CYC` (at least 2) consecutive all-off cycles. Moving from all-off to a pattern is allowed once that count has been reached.
- R9: The period is `PERIOD` = round(CLK_HZ/PWM_HZ) cycles. At each wrap the phase returns to drive, whatever decay came before.
- R10: With `sign_pos` = 0, the drive pattern is 4'b0110 and the fast-decay pattern is 4'b1001.
- R11: The high side and the low side of one bridge leg are never on together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Enable; low forces all gates off and holds the period count |
| trip | input | 1 | Current comparator output, high when the winding current has reached the setpoint |
| sign_pos | input | 1 | Winding current sign from the indexer; 1 = current from output 1 to output 2 |
| zero_set | input | 1 | Setpoint magnitude is zero |
| decay_sel | input | 2 | 00 slow, 01 mixed, 10 or 11 fast |
| gate | output | 4 | {hs_out1, ls_out1, hs_out2, ls_out2} gate commands |

## Verification
The embedded assertions check a set of properties on every cycle. Leg exclusivity must always hold. Two different conducting patterns must never follow one another directly. The gates must be off after a disabled cycle. The counter must wrap and the phase must restart at each period end. Blanking and a zero setpoint must hold the drive phase. The exact length of the dead gap, the length of the fast part of mixed decay measured from the trip point, and the pattern each sign produces are shown only by the bench. It runs a timing reference model against the design on every clock over directed scenarios (blanking pulses, each decay mode, sign flips mid-drive, disabling mid-period) and a mixed stimulus run.

// File: rtl/chop_pkg.sv
// Shared types and gate patterns for the winding current chopper.
// Assumes gate bit order {hs_out1, ls_out1, hs_out2, ls_out2}.
package chop_pkg;

    typedef enum logic [1:0] {
        PH_DRIVE = 2'd0,
        PH_FAST  = 2'd1,
        PH_SLOW  = 2'd2
    } phase_t;

    localparam logic [1:0] DK_SLOW  = 2'b00;
    localparam logic [1:0] DK_MIXED = 2'b01;

    localparam logic [3:0] PAT_POS  = 4'b1001;
    localparam logic [3:0] PAT_NEG  = 4'b0110;
    localparam logic [3:0] PAT_SLOW = 4'b0101;

    // Map the chopping phase and the winding sign to a bridge pattern.
    function automatic logic [3:0] bridge_pattern(phase_t ph, logic sign_pos, logic zero_set);
        logic [3:0] pat;
        case (ph)
            PH_DRIVE: pat = zero_set ? PAT_SLOW : (sign_pos ? PAT_POS : PAT_NEG);
            PH_FAST:  pat = sign_pos ? PAT_NEG : PAT_POS;
            default:  pat = PAT_SLOW;
        endcase
        return pat;
    endfunction

endpackage

// File: rtl/chop_period_timer.sv
// Period counter for the chopper. Counts 0..PERIOD-1 and wraps.
// It reports the last cycle of a period and whether the count is still inside
// the blanking window. Assumes BLANK < PERIOD.
module chop_period_timer #(
    parameter int PERIOD = 1667,
    parameter int BLANK  = 200,
    localparam int CW    = $clog2(PERIOD)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    output logic [CW-1:0] cnt,
    output logic          last,
    output logic          blanked
);
    localparam logic [CW-1:0] LAST_CNT = CW'(PERIOD - 1);
    localparam logic [CW-1:0] BLANK_CNT = CW'(BLANK);

    // Advance the period count, hold it at zero while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt <= '0;
        end else if (cnt == LAST_CNT) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign last    = (cnt == LAST_CNT);
    assign blanked = (cnt < BLANK_CNT);

    p_count_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST_CNT);
    p_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        en && last |=> cnt == '0);
    p_hold_disabled_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> cnt == '0);

endmodule

// File: rtl/chop_phase_fsm.sv
// Chopping phase sequencer: drive at the period start, decay after an
// accepted comparator trip, with a timed fast segment for mixed decay.
// Assumes trip is already synchronous to clk.
module chop_phase_fsm
    import chop_pkg::*;
#(
    parameter int PERIOD = 1667,
    localparam int CW    = $clog2(PERIOD)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [CW-1:0] cnt,
    input  logic          last,
    input  logic          blanked,
    input  logic          trip,
    input  logic          zero_set,
    input  logic [1:0]    decay_sel,
    output phase_t        phase
);
    localparam logic [CW-1:0] LAST_CNT = CW'(PERIOD - 1);

    phase_t        phase_q, phase_d;
    logic [CW-1:0] fast_left_q, fast_left_d;
    logic          mixed_q, mixed_d;
    logic [CW-1:0] fast_len;
    logic          accept;

    // Fast segment for mixed decay: a quarter of the cycles left after this one.
    assign fast_len = (LAST_CNT - cnt) >> 2;
    assign accept   = trip && !blanked && !zero_set;

    // Choose the next phase from the period position, trip and decay mode.
    always_comb begin
        phase_d     = phase_q;
        fast_left_d = fast_left_q;
        mixed_d     = mixed_q;
        if (!en || last) begin
            phase_d     = PH_DRIVE;
            fast_left_d = '0;
            mixed_d     = 1'b0;
        end else begin
            case (phase_q)
                PH_DRIVE: begin
                    if (accept) begin
                        if (decay_sel == DK_SLOW) begin
                            phase_d = PH_SLOW;
                        end else if (decay_sel == DK_MIXED) begin
                            if (fast_len == '0) begin
                                phase_d = PH_SLOW;
                            end else begin
                                phase_d     = PH_FAST;
                                fast_left_d = fast_len;
                                mixed_d     = 1'b1;
                            end
                        end else begin
                            phase_d = PH_FAST;
                            mixed_d = 1'b0;
                        end
                    end
                end
                PH_FAST: begin
                    if (mixed_q) begin
                        if (fast_left_q <= 1) begin
                            phase_d = PH_SLOW;
                        end
                        fast_left_d = (fast_left_q == '0) ? '0 : fast_left_q - 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // Register the phase and the mixed-decay bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q     <= PH_DRIVE;
            fast_left_q <= '0;
            mixed_q     <= 1'b0;
        end else begin
            phase_q     <= phase_d;
            fast_left_q <= fast_left_d;
            mixed_q     <= mixed_d;
        end
    end

    assign phase = phase_q;

    p_blank_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        en && phase_q == PH_DRIVE && blanked |=> phase_q == PH_DRIVE);
    p_zero_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        en && zero_set && phase_q == PH_DRIVE |=> phase_q == PH_DRIVE);
    p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        en && last |=> phase_q == PH_DRIVE);
    p_slow_sticks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        en && !last && phase_q == PH_SLOW |=> phase_q == PH_SLOW);

endmodule

// File: rtl/chop_dead_time.sv
// Dead-time insertion for one full bridge. A new conducting pattern is applied
// only after the gates have been all off for DEAD consecutive cycles.
// Assumes target is never all-off while enabled.
module chop_dead_time #(
    parameter int DEAD = 2,
    localparam int OW  = $clog2(DEAD + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic [3:0] target,
    output logic [3:0] gate
);
    localparam logic [OW-1:0] DEAD_CNT = OW'(DEAD);

    logic [3:0]    gate_q, gate_d;
    logic [OW-1:0] off_q, off_d;

    // Decide the next applied pattern under the dead-time rule.
    always_comb begin
        if (!en) begin
            gate_d = 4'b0000;
        end else if (target == gate_q) begin
            gate_d = gate_q;
        end else if (gate_q != 4'b0000) begin
            gate_d = 4'b0000;
        end else if (off_q >= DEAD_CNT) begin
            gate_d = target;
        end else begin
            gate_d = 4'b0000;
        end
    end

    // Count consecutive all-off cycles, saturating at DEAD.
    always_comb begin
        if (gate_d != 4'b0000) begin
            off_d = '0;
        end else if (gate_q != 4'b0000) begin
            off_d = OW'(1);
        end else if (off_q < DEAD_CNT) begin
            off_d = off_q + 1'b1;
        end else begin
            off_d = off_q;
        end
    end

    // Register the gates; reset starts with the gap already satisfied.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_q <= 4'b0000;
            off_q  <= DEAD_CNT;
        end else begin
            gate_q <= gate_d;
            off_q  <= off_d;
        end
    end

    assign gate = gate_q;

    p_no_direct_swap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        gate_q != 4'b0000 |=> (gate_q == 4'b0000 || gate_q == $past(gate_q)));
    p_leg_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_q[3] && gate_q[2]) && !(gate_q[1] && gate_q[0]));
    p_off_when_disabled_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> gate_q == 4'b0000);

endmodule

// File: rtl/chop_ctrl.sv
// Fixed-frequency current chopper for one winding. It ties together the
// period timer, the phase sequencer and the dead-time stage. Assumes trip,
// sign_pos, zero_set and decay_sel are synchronous to clk.
module chop_ctrl
    import chop_pkg::*;
#(
    parameter int CLK_HZ   = 50_000_000,
    parameter int PWM_HZ   = 30_000,
    parameter int BLANK_NS = 4000,
    parameter int DEAD_CYC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       trip,
    input  logic       sign_pos,
    input  logic       zero_set,
    input  logic [1:0] decay_sel,
    output logic [3:0] gate
);
    localparam int PERIOD = (CLK_HZ + PWM_HZ / 2) / PWM_HZ;
    localparam int BLANK  = ((CLK_HZ / 1000) * BLANK_NS) / 1_000_000;
    localparam int DEAD   = (DEAD_CYC < 2) ? 2 : DEAD_CYC;
    localparam int CW     = $clog2(PERIOD);

    logic [CW-1:0] cnt;
    logic          last;
    logic          blanked;
    phase_t        phase;
    logic [3:0]    target;

    chop_period_timer #(.PERIOD(PERIOD), .BLANK(BLANK)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .cnt     (cnt),
        .last    (last),
        .blanked (blanked)
    );

    chop_phase_fsm #(.PERIOD(PERIOD)) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .cnt       (cnt),
        .last      (last),
        .blanked   (blanked),
        .trip      (trip),
        .zero_set  (zero_set),
        .decay_sel (decay_sel),
        .phase     (phase)
    );

    // Translate the phase into the wanted bridge pattern.
    always_comb begin
        target = bridge_pattern(phase, sign_pos, zero_set);
    end

    chop_dead_time #(.DEAD(DEAD)) u_dead (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en),
        .target (target),
        .gate   (gate)
    );

endmodule

// File: tb/chop_ctrl_test.sv
module chop_ctrl_test;
    localparam int CLK_PERIOD = 10;
    // CLK_HZ 1.8 MHz: period round(1.8e6/30e3) = 60, blanking 1800*4000/1e6 = 7.
    localparam int P = 60;
    localparam int B = 7;
    localparam int D = 2;

    logic       clk = 1'b0;
    logic       rst_n, en, trip, sign_pos, zero_set;
    logic [1:0] decay_sel;
    logic [3:0] gate;

    int    n_chk = 0, n_fail = 0, cyc_total = 0;
    string cur_req = "R1";
    bit    done = 0;

    chop_ctrl #(.CLK_HZ(1_800_000), .DEAD_CYC(D)) uut (
        .clk(clk), .rst_n(rst_n), .en(en), .trip(trip), .sign_pos(sign_pos),
        .zero_set(zero_set), .decay_sel(decay_sel), .gate(gate)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(string req, logic [3:0] got, logic [3:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: gate=%b expected %b at %0t", req, got, exp, $time);
        end
    endtask

    // Reference model: period position, trip record, gap counter.
    int         m_cnt = 0, m_trip_at = -1, m_off = D;
    logic [1:0] m_mode = 2'b00;
    logic [3:0] m_gate = 4'b0000;

    function automatic logic [3:0] m_target();
        logic [3:0] drv, rev;
        drv = sign_pos ? 4'b1001 : 4'b0110;
        rev = sign_pos ? 4'b0110 : 4'b1001;
        if (m_trip_at < 0) return zero_set ? 4'b0101 : drv;
        case (m_mode)
            2'b00:   return 4'b0101;
            2'b01:   return (m_cnt <= m_trip_at + (P - 1 - m_trip_at) / 4) ? rev : 4'b0101;
            default: return rev;
        endcase
    endfunction

    always @(posedge clk) begin
        logic [3:0] tgt, nxt;
        cyc_total++;
        if (!rst_n) begin
            m_cnt = 0; m_trip_at = -1; m_gate = 4'b0000; m_off = D;
        end else begin
            tgt = m_target();
            if (!en) nxt = 4'b0000;
            else if (tgt == m_gate) nxt = m_gate;
            else if (m_gate != 4'b0000) nxt = 4'b0000;
            else if (m_off >= D) nxt = tgt;
            else nxt = 4'b0000;
            if (nxt != 4'b0000) m_off = 0;
            else if (m_gate != 4'b0000) m_off = 1;
            else if (m_off < D) m_off++;
            m_gate = nxt;
            if (!en || m_cnt == P - 1) begin
                m_cnt = 0; m_trip_at = -1;
            end else begin
                if (m_trip_at < 0 && trip && m_cnt >= B && !zero_set) begin
                    m_trip_at = m_cnt; m_mode = decay_sel;
                end
                m_cnt++;
            end
        end
    end

    // Every-clock comparison against the model, plus leg exclusivity (R11).
    always @(negedge clk) begin
        if (!done) begin
            check(cur_req, gate, m_gate);
            n_chk++;
            if ((gate[3] && gate[2]) || (gate[1] && gate[0])) begin
                n_fail++;
                $display("FAIL R11: gate=%b expected no leg with both switches on", gate);
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        if (cyc_total > 20000 && !done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: cycles=%0d expected below 20000", cyc_total);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic cyc(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_cnt(int n);
        do @(negedge clk); while (m_cnt != n);
    endtask

    initial begin
        rst_n = 0; en = 0; trip = 0; sign_pos = 1; zero_set = 0; decay_sel = 2'b00;
        cyc(4);
        check("R1 reset", gate, 4'b0000);
        rst_n = 1;
        cyc(5);
        check("R1 disabled", gate, 4'b0000);

        // Slow decay with trip held from the period start.
        cur_req = "R4"; decay_sel = 2'b00; trip = 1; en = 1;
        cyc(2);  check("R2 positive drive", gate, 4'b1001);
        wait_cnt(6);  check("R3 blanking holds drive", gate, 4'b1001);
        wait_cnt(30); check("R4 slow decay", gate, 4'b0101);
        cur_req = "R9";
        wait_cnt(3);  check("R9 period restart", gate, 4'b1001);

        // Mixed decay, trip at count 20: fast 9 cycles then slow.
        cur_req = "R6"; decay_sel = 2'b01; trip = 0;
        wait_cnt(20); trip = 1; cyc(1); trip = 0;
        wait_cnt(26); check("R6 mixed fast part", gate, 4'b0110);
        wait_cnt(40); check("R6 mixed slow part", gate, 4'b0101);

        // Trip pulse inside the blanking window.
        cur_req = "R3";
        wait_cnt(2); trip = 1; wait_cnt(6); trip = 0;
        wait_cnt(30); check("R3 blanked trip ignored", gate, 4'b1001);

        // Fast decay, both encodings.
        cur_req = "R5"; decay_sel = 2'b10;
        wait_cnt(15); trip = 1; cyc(1); trip = 0;
        wait_cnt(30); check("R5 fast decay 10", gate, 4'b0110);
        decay_sel = 2'b11;
        wait_cnt(15); trip = 1; cyc(1); trip = 0;
        wait_cnt(30); check("R5 fast decay 11", gate, 4'b0110);

        // Negative sign.
        cur_req = "R10"; sign_pos = 0; decay_sel = 2'b00;
        wait_cnt(10); check("R10 negative drive", gate, 4'b0110);
        wait_cnt(20); trip = 1; cyc(1); trip = 0;
        wait_cnt(35); check("R10 slow after negative", gate, 4'b0101);

        // Sign flip mid-drive: two off cycles, then new pattern.
        cur_req = "R8";
        wait_cnt(10); sign_pos = 1;
        cyc(1); check("R8 gap cycle 1", gate, 4'b0000);
        cyc(1); check("R8 gap cycle 2", gate, 4'b0000);
        cyc(1); check("R8 new drive", gate, 4'b1001);

        // Zero setpoint: slow all period, trips not accepted.
        cur_req = "R7"; zero_set = 1; trip = 1; decay_sel = 2'b01;
        wait_cnt(5);  check("R7 zero at start", gate, 4'b0101);
        wait_cnt(40); check("R7 zero late", gate, 4'b0101);
        zero_set = 0; trip = 0;

        // Disable mid-period.
        cur_req = "R1";
        wait_cnt(10); en = 0;
        cyc(1); check("R1 disable mid-drive", gate, 4'b0000);
        cyc(3); check("R1 still disabled", gate, 4'b0000);
        en = 1;
        cyc(1); check("R1 re-enable drive", gate, 4'b1001);

        // Mixed stimulus run.
        cur_req = "R8 mixed run";
        for (int i = 0; i < 600; i++) begin
            trip      = (i % 13 == 0) || (i % 29 < 3);
            decay_sel = 2'((i / 60) % 4);
            if (i % 97 == 0) sign_pos = ~sign_pos;
            zero_set  = (i % 211 < 20);
            en        = !(i % 251 < 4);
            cyc(1);
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule